// File: doc/BRIEF.md
# Banked Internal Data Memory Decoder

This block is the internal data address space of a small 8-bit controller. It holds a 256-byte RAM and a window of special function registers (SFRs), and routes each access from the instruction path to the right storage. One access is presented per cycle. It comes in one of four kinds: a direct byte address, an indirect byte address taken from a pointer register, a banked register number, or a single-bit address.

The same upper half of the byte address range (0x80 to 0xFF) leads to two different places. Direct accesses reach the SFRs. Indirect accesses reach the upper 128 bytes of RAM. In total, 384 bytes can be addressed. Banked register accesses land in one of four groups of eight bytes at the bottom of RAM. The group is chosen by a 2-bit bank field held in a status SFR. Bit accesses reach a 16-byte flag area of RAM, or any SFR whose address is a multiple of 8. A bit write is done as a read-modify-write of the containing byte within the one access cycle.

Read data is registered. It appears one cycle after the access, together with a valid flag. For a write access, the returned data is the content before the write.

Top module: `idata_router`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, and the status SFR at 0xD0 reads 0x00, so bank 0 is selected.
- R2: The access kind is set by `acc_mode`: 0 = direct, 1 = indirect, 2 = register, 3 = bit. A direct access to 0x00–0x7F reads or writes RAM at that address. The read value appears on `rd_data` with `rd_valid` high on the cycle after the access.
- R3: A direct access to 0x80–0xFF reaches the SFR window. The SFRs at addresses that are multiples of 8 are implemented and hold written values. They are separate from the RAM bytes at the same addresses.
- R4: An indirect access uses as its address the content of R0 (`acc_reg[0]`=0) or R1 (`acc_reg[0]`=1) of the current bank. It reaches RAM over the full range 0x00–0xFF and never the SFRs.
- R5: A register access reaches RAM byte bank*8 + `acc_reg`.
- R6: The bank is bits [4:3] of the status SFR at 0xD0. A write to it applies from the next access on.
- R7: Bit addresses 0x00–0x7F select bit (addr & 7) of RAM byte 0x20 + (addr >> 3). A bit read returns that bit in `rd_data[0]`, with `rd_data[7:1]` = 0.
- R8: Bit addresses 0x80–0xFF select bit (addr & 7) of the SFR at (addr & 0xF8).
- R9: A bit write sets the selected bit to `wdata[0]` in one access and leaves the other seven bits of the byte unchanged. The next access sees the new value.
- R10: A write to an SFR address that is not a multiple of 8 is ignored, and a read of one returns 0x00.
- R11: While `acc_en` is low, nothing is written, and `rd_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | Access kind: 0 direct, 1 indirect, 2 register, 3 bit |
| acc_addr | input | 8 | Direct byte address or bit address |
| acc_reg | input | 3 | Register number; bit 0 picks R0/R1 for indirect |
| wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rd_valid | output | 1 | Registered: an access happened last cycle |
| rd_data | output | 8 | Registered read value (pre-write content on writes) |

## Verification
Every result is due exactly one clock edge after the access is presented. The bench drives each access on a falling edge, lets one rising edge pass, and samples `rd_valid` and `rd_data` on the next falling edge. The expected value is computed from the model state as it stood before that edge. Writes, including bank changes through the status SFR, update the model only after that edge. As a result, the access that immediately follows a write is checked against the new contents, which covers the same-cycle read-modify-write of bit accesses.

// File: rtl/idata_pkg.sv
// Package: shared types for the internal data address space.
// Assumes byte-wide storage and an 8-bit address space.
package idata_pkg;

    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_REGISTER = 2'd2,
        ACC_BIT      = 2'd3
    } acc_kind_e;

    // Resolved storage target of one access
    typedef struct packed {
        logic       is_sfr;
        logic       is_bit;
        logic [7:0] byte_addr;
        logic [2:0] bit_idx;
    } tgt_t;

endpackage

// File: rtl/idata_addr_map.sv
// Address map: resolves an access into a storage target.
// Purely combinational. Assumes the pointer byte (R0/R1 of the current
// bank) is already read from RAM by the caller.
module idata_addr_map
    import idata_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int REG_W   = 3,
    parameter logic [7:0] FLAG_BASE = 8'h20
) (
    input  logic [1:0]        acc_mode,
    input  logic [7:0]        acc_addr,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        ptr_val,
    output tgt_t              tgt
);
    localparam int PAD_W = 8 - BANK_W - REG_W;

    // Route the address by access kind
    always_comb begin
        tgt = '0;
        unique case (acc_kind_e'(acc_mode))
            ACC_DIRECT: begin
                tgt.is_sfr    = acc_addr[7];
                tgt.byte_addr = acc_addr;
            end
            ACC_INDIRECT: begin
                tgt.byte_addr = ptr_val;
            end
            ACC_REGISTER: begin
                tgt.byte_addr = {{PAD_W{1'b0}}, bank, acc_reg};
            end
            ACC_BIT: begin
                tgt.is_bit  = 1'b1;
                tgt.bit_idx = acc_addr[2:0];
                if (acc_addr[7]) begin
                    tgt.is_sfr    = 1'b1;
                    tgt.byte_addr = {acc_addr[7:3], 3'b000};
                end else begin
                    tgt.byte_addr = FLAG_BASE | {4'b0000, acc_addr[6:3]};
                end
            end
            default: tgt = '0;
        endcase
    end
endmodule

// File: rtl/idata_ram.sv
// RAM: byte array with one write port and two asynchronous read ports
// (access target and pointer register). Contents are not reset.
module idata_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte per write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read ports
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/idata_sfr_file.sv
// SFR window: implements one register at each upper address that is a
// multiple of 8. Other upper addresses read 0 and ignore writes.
// Exposes the bank field of the status register.
module idata_sfr_file #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter logic [7:0] STATUS_ADDR = 8'hD0,
    parameter int BANK_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [BANK_W-1:0] bank
);
    localparam int SLOT_SH = 3;
    localparam int SLOTS   = 1 << (7 - SLOT_SH);
    localparam int SLOT_W  = 7 - SLOT_SH;
    localparam logic [SLOT_W-1:0] STATUS_SLOT = STATUS_ADDR[6:SLOT_SH];

    logic [DATA_W-1:0] regs [SLOTS];
    logic              hit;
    logic [SLOT_W-1:0] slot;

    assign hit  = addr[7] && (addr[SLOT_SH-1:0] == '0);
    assign slot = addr[6:SLOT_SH];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Hold one implemented SFR, cleared on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && hit && (slot == SLOT_W'(i)))
                regs[i] <= wdata;
        end
    end

    // Return register contents, zero when unimplemented
    always_comb begin
        rdata = hit ? regs[slot] : '0;
    end

    assign bank = regs[STATUS_SLOT][BANK_LSB +: BANK_W];
endmodule

// File: rtl/idata_router.sv
// Top: internal data address space with banked registers, a split upper
// region (SFR when direct, RAM when indirect) and bit read-modify-write.
// Assumes one access per cycle; read data is registered one cycle later.
module idata_router
    import idata_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    parameter logic [7:0] STATUS_ADDR = 8'hD0,
    parameter int BANK_LSB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [1:0]       acc_mode,
    input  logic [7:0]       acc_addr,
    input  logic [REG_W-1:0] acc_reg,
    input  logic [7:0]       wdata,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    localparam int PTR_PAD = 8 - BANK_W - REG_W;

    logic [BANK_W-1:0] bank;
    logic [7:0]        ptr_addr, ptr_val;
    logic [7:0]        ram_rd, sfr_rd, cur_byte, new_byte, rd_val;
    logic              ram_we, sfr_we;
    tgt_t              tgt;

    // Pointer register R0/R1 of the current bank
    assign ptr_addr = {{PTR_PAD{1'b0}}, bank, {(REG_W-1){1'b0}}, acc_reg[0]};

    idata_addr_map #(.BANK_W(BANK_W), .REG_W(REG_W)) u_map (
        .acc_mode(acc_mode), .acc_addr(acc_addr), .acc_reg(acc_reg),
        .bank(bank), .ptr_val(ptr_val), .tgt(tgt)
    );

    idata_ram #(.ADDR_W(8), .DATA_W(8)) u_ram (
        .clk(clk), .we(ram_we), .waddr(tgt.byte_addr), .wdata(new_byte),
        .raddr_a(tgt.byte_addr), .rdata_a(ram_rd),
        .raddr_b(ptr_addr), .rdata_b(ptr_val)
    );

    idata_sfr_file #(.DATA_W(8), .BANK_W(BANK_W), .STATUS_ADDR(STATUS_ADDR),
                     .BANK_LSB(BANK_LSB)) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(tgt.byte_addr),
        .wdata(new_byte), .rdata(sfr_rd), .bank(bank)
    );

    // Select the current byte and build the merged write byte
    always_comb begin
        cur_byte = tgt.is_sfr ? sfr_rd : ram_rd;
        new_byte = wdata;
        rd_val   = cur_byte;
        if (tgt.is_bit) begin
            new_byte = cur_byte;
            new_byte[tgt.bit_idx] = wdata[0];
            rd_val   = {7'b0, cur_byte[tgt.bit_idx]};
        end
    end

    assign ram_we = acc_en && acc_wr && !tgt.is_sfr;
    assign sfr_we = acc_en && acc_wr &&  tgt.is_sfr;

    // Register the read result and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_en;
            if (acc_en) rd_data <= rd_val;
        end
    end
endmodule

// File: rtl/idata_router_chk.sv
// Checker: temporal properties of the data address space, bound to the top.
module idata_router_chk #(
    parameter logic [7:0] STATUS_ADDR = 8'hD0,
    parameter int BANK_LSB = 3,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [1:0]        acc_mode,
    input logic [7:0]        acc_addr,
    input logic [7:0]        wdata,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic [BANK_W-1:0] bank
);
    AST_VALID_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> rd_valid); // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !rd_valid); // R11
    AST_UNIMPL_SFR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd0 && acc_addr[7] && acc_addr[2:0] != 3'd0)
        |=> (rd_data == 8'h00)); // R10
    AST_BIT_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd3) |=> (rd_data[7:1] == 7'd0)); // R7
    AST_BANK_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_mode == 2'd0 && acc_addr == STATUS_ADDR)
        |=> (bank == $past(wdata[BANK_LSB +: BANK_W]))); // R6
endmodule

bind idata_router idata_router_chk #(
    .STATUS_ADDR(STATUS_ADDR), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_mode(acc_mode), .acc_addr(acc_addr), .wdata(wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .bank(bank)
);

// File: tb/idata_router_bench.sv
module idata_router_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0;
    logic [1:0] acc_mode = 2'd0;
    logic [7:0] acc_addr = 8'd0;
    logic [2:0] acc_reg = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_ram [256];
    logic [7:0] ref_sfr [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    idata_router u_idata_router (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_mode(acc_mode), .acc_addr(acc_addr), .acc_reg(acc_reg),
        .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [1:0] cur_bank();
        return ref_sfr[26][4:3];
    endfunction

    // Target of an access: sfr flag, byte address, bit flag, bit index
    function automatic logic [12:0] resolve(logic [1:0] m, logic [7:0] a, logic [2:0] r);
        logic [7:0] b;
        case (m)
            2'd0: return {a[7], a, 1'b0, 3'd0};
            2'd1: begin
                b = ref_ram[{3'b000, cur_bank(), 2'b00, r[0]}];
                return {1'b0, b, 1'b0, 3'd0};
            end
            2'd2: return {1'b0, {3'b000, cur_bank(), r}, 1'b0, 3'd0};
            default: begin
                if (a[7]) return {1'b1, {a[7:3], 3'b000}, 1'b1, a[2:0]};
                else      return {1'b0, {4'b0010, a[6:3]}, 1'b1, a[2:0]};
            end
        endcase
    endfunction

    function automatic logic [7:0] byte_at(logic s, logic [7:0] b);
        if (!s) return ref_ram[b];
        return (b[2:0] == 3'd0) ? ref_sfr[b[7:3]] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] m, logic [7:0] a, logic [2:0] r);
        logic [12:0] t = resolve(m, a, r);
        logic [7:0] v = byte_at(t[12], t[11:4]);
        return t[3] ? {7'b0, v[t[2:0]]} : v;
    endfunction

    task automatic model_write(logic [1:0] m, logic [7:0] a, logic [2:0] r, logic [7:0] d);
        logic [12:0] t = resolve(m, a, r);
        logic [7:0] v = byte_at(t[12], t[11:4]);
        if (t[3]) v[t[2:0]] = d[0]; else v = d;
        if (!t[12]) ref_ram[t[11:4]] = v;
        else if (t[6:4] == 3'd0) ref_sfr[t[11:7]] = v;
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One access: drive at falling edge, result sampled one edge later
    task automatic access(string tag, logic w, logic [1:0] m, logic [7:0] a,
                          logic [2:0] r, logic [7:0] d);
        logic [7:0] e;
        acc_en = 1'b1; acc_wr = w; acc_mode = m; acc_addr = a; acc_reg = r; wdata = d;
        e = exp_read(m, a, r);
        @(posedge clk);
        if (w) model_write(m, a, r, d);
        @(negedge clk);
        check({tag, " valid"}, {7'b0, rd_valid}, 8'd1);
        check(tag, rd_data, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4660));
        for (int i = 0; i < 32; i++) ref_sfr[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", {7'b0, rd_valid}, 8'd0);
        check("R1 rd_data", rd_data, 8'd0);
        access("R1 status", 1'b0, 2'd0, 8'hD0, 3'd0, 8'h00);
        check("R1 status zero", rd_data, 8'h00);

        // Initialise RAM: low half direct, upper half indirect through R0
        for (int i = 0; i < 128; i++)
            access("R2 init", 1'b1, 2'd0, 8'(i), 3'd0, 8'($urandom));
        for (int i = 128; i < 256; i++) begin
            access("R5 init", 1'b1, 2'd2, 8'd0, 3'd0, 8'(i));
            access("R4 init", 1'b1, 2'd1, 8'd0, 3'd0, 8'($urandom));
        end
        access("R5 init", 1'b1, 2'd2, 8'd0, 3'd0, 8'h33);

        // R2 direct low RAM
        access("R2 write", 1'b1, 2'd0, 8'h45, 3'd0, 8'hA5);
        access("R2 read", 1'b0, 2'd0, 8'h45, 3'd0, 8'h00);
        check("R2 value", rd_data, 8'hA5);
        // R3/R4 split upper region
        access("R3 sfr write", 1'b1, 2'd0, 8'h90, 3'd0, 8'h3C);
        access("R5 set R1", 1'b1, 2'd2, 8'd0, 3'd1, 8'h90);
        access("R4 ind write", 1'b1, 2'd1, 8'd0, 3'd1, 8'h77);
        access("R3 sfr read", 1'b0, 2'd0, 8'h90, 3'd0, 8'h00);
        check("R3 value", rd_data, 8'h3C);
        access("R4 ind read", 1'b0, 2'd1, 8'd0, 3'd1, 8'h00);
        check("R4 value", rd_data, 8'h77);
        // R6/R5 bank switch
        access("R6 bank3", 1'b1, 2'd0, 8'hD0, 3'd0, 8'h18);
        access("R5 bank3 write", 1'b1, 2'd2, 8'd0, 3'd2, 8'h5E);
        access("R6 bank0", 1'b1, 2'd0, 8'hD0, 3'd0, 8'h00);
        access("R5 bank3 byte", 1'b0, 2'd0, 8'h1A, 3'd0, 8'h00);
        check("R5 value", rd_data, 8'h5E);
        // R7/R9 bit RMW in flag area
        access("R9 clear byte", 1'b1, 2'd0, 8'h2C, 3'd0, 8'hF0);
        access("R9 bit set", 1'b1, 2'd3, 8'h63, 3'd0, 8'h01);
        access("R9 byte", 1'b0, 2'd0, 8'h2C, 3'd0, 8'h00);
        check("R9 neighbours kept", rd_data, 8'hF8);
        access("R7 bit one", 1'b0, 2'd3, 8'h63, 3'd0, 8'h00);
        access("R7 bit zero", 1'b0, 2'd3, 8'h62, 3'd0, 8'h00);
        check("R7 value", rd_data, 8'h00);
        // R8 SFR bit
        access("R8 sfr clear", 1'b1, 2'd0, 8'hF0, 3'd0, 8'h00);
        access("R8 bit set", 1'b1, 2'd3, 8'hF5, 3'd0, 8'hFF);
        access("R8 sfr read", 1'b0, 2'd0, 8'hF0, 3'd0, 8'h00);
        check("R8 value", rd_data, 8'h20);
        // R10 unimplemented SFR
        access("R10 write", 1'b1, 2'd0, 8'h81, 3'd0, 8'hFF);
        access("R10 read", 1'b0, 2'd0, 8'h81, 3'd0, 8'h00);
        check("R10 value", rd_data, 8'h00);
        access("R10 slot", 1'b0, 2'd0, 8'h80, 3'd0, 8'h00);
        // R11 idle cycle with write strobe
        acc_en = 1'b0; acc_wr = 1'b1; acc_mode = 2'd0; acc_addr = 8'h45; wdata = 8'h11;
        @(negedge clk);
        check("R11 no valid", {7'b0, rd_valid}, 8'd0);
        access("R11 unchanged", 1'b0, 2'd0, 8'h45, 3'd0, 8'h00);
        check("R11 value", rd_data, 8'hA5);

        // Random mixed accesses against the model
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] m = 2'($urandom);
            case (m)
                2'd0: access("R2/R3 random direct", ($urandom % 3) == 0, m,
                             8'($urandom), 3'($urandom), 8'($urandom));
                2'd1: access("R4 random indirect", ($urandom % 3) == 0, m,
                             8'($urandom), 3'($urandom), 8'($urandom));
                2'd2: access("R5 random register", ($urandom % 3) == 0, m,
                             8'($urandom), 3'($urandom), 8'($urandom));
                default: access("R7/R8/R9 random bit", ($urandom % 3) == 0, m,
                             8'($urandom), 3'($urandom), 8'($urandom));
            endcase
        end
        acc_en = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end
endmodule